// File: doc/BRIEF.md
# Dual-Device SPI Memory Front End

This block is the serial slave front end of a chip that shows two logical devices behind one chip select. The first device is a byte-wide memory array of 2^ADDR_W bytes (32,768 by default) addressed by a two-byte address. The second device is a small companion register file of NREG registers (30 by default) addressed by one byte. Each device answers its own opcodes, so the host treats them as two separate parts on the same bus. The storage itself lies outside the block. The front end drives a memory port and a register port with combinational read data, and it commits each byte at bus speed with no busy period between bytes.

The block samples the SPI lines with the system clock. It assembles bytes in mode 0, most significant bit first, decodes the opcode and sequences the address and data bytes. The address advances after every data byte. Memory writes are gated by a write-enable latch and by two block-protect bits held in a status byte. A supervisor lockout input, sampled while chip select is high, causes the whole next transaction to be ignored.

Top module: `spi_dual_front`

## Requirements
- R1: After reset, miso is 0, no write strobe fires, and a status read (opcode 0x05) returns 0x00.
- R2: Opcode 0x03 with a two-byte address returns the byte at that address and then successive bytes. The address is the low ADDR_W bits of the 16-bit address, and it wraps from the top address to 0.
- R3: Opcode 0x02 with a two-byte address writes every following complete byte to successive addresses with no gap cycles, and the address wraps from the top address to 0.
- R4: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. The status byte reads as {4'b0, protect[1:0] at bits 3:2, latch at bit 1, 1'b0}.
- R5: A memory write with the latch clear is discarded. The latch clears when chip select rises after an opcode 0x02 or 0x01 transaction.
- R6: Opcode 0x01 with the latch set loads the protect bits from data bits 3:2. With the latch clear it has no effect.
- R7: Memory writes are discarded for protect 00 at no address, for 01 in the upper quarter, for 10 in the upper half and for 11 at every address.
- R8: Opcode 0x12 writes, and opcode 0x13 reads, companion registers from a one-byte start address. The address wraps from NREG-1 to 0. These writes need neither the latch nor the protect setting.
- R9: If lockout is high before chip select falls, that transaction is ignored: nothing is written, the latch is unchanged and miso stays 0.
- R10: A partial byte that is cut off by chip select rising is not committed.
- R11: An unrecognised opcode and the bytes after it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI lines |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sclk | input | 1 | SPI serial clock, mode 0 |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| lockout | input | 1 | Supervisor lockout; blocks the next transaction |
| mem_addr | output | ADDR_W | Memory array byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe, one cycle per byte |
| mem_rdata | input | 8 | Memory read data for mem_addr |
| reg_addr | output | $clog2(NREG) | Companion register address |
| reg_wdata | output | 8 | Companion register write data |
| reg_we | output | 1 | Companion register write strobe |
| reg_rdata | input | 8 | Companion register read data |

## Verification
The bench builds the block with ADDR_W=8 and NREG=30. This makes the array 256 bytes, so full-array burst writes and reads fit in the run. For each of the four protect settings the bench writes and reads back every address, which covers both protect boundaries and the wrap from 0xFF to 0. With a register count of 30, which is not a power of two, a burst from register 28 crosses the wrap at 29, and a 32-byte read covers the whole register file.

// File: rtl/spi_dual_pkg.sv
// Shared opcode values and transaction phases for the dual-device SPI front end.
// Assumes byte-wide opcodes; memory and companion opcodes never overlap.
package spi_dual_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_CWR   = 8'h12;
    localparam logic [7:0] OP_CRD   = 8'h13;

    typedef enum logic [3:0] {
        PH_OPC, PH_AHI, PH_ALO, PH_MWR, PH_MRD,
        PH_SRD, PH_SWR, PH_CADR, PH_CWR, PH_CRD, PH_IGN
    } phase_t;
endpackage

// File: rtl/spi_dual_shifter.sv
// Serial byte engine: samples cs_n/sclk/mosi with clk, assembles bytes on
// sclk rising edges (mode 0, MSB first) and shifts miso on falling edges.
// Assumes sclk is slower than clk/4. A partial byte is dropped when cs_n rises.
module spi_dual_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic [7:0] load_byte,
    output logic       cs_act,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       load_req,
    output logic       miso_bit
);
    logic       cs_q, sclk_q, sclk_qq, mosi_q;
    logic [2:0] cnt;
    logic [6:0] sh;
    logic [7:0] tx;
    logic       rise, fall;

    // Capture the bus lines in the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b1;
            sclk_q  <= 1'b0;
            sclk_qq <= 1'b0;
            mosi_q  <= 1'b0;
        end else begin
            cs_q    <= cs_n;
            sclk_q  <= sclk;
            sclk_qq <= sclk_q;
            mosi_q  <= mosi;
        end
    end

    assign cs_act    = ~cs_q;
    assign rise      = sclk_q & ~sclk_qq & cs_act;
    assign fall      = ~sclk_q & sclk_qq & cs_act;
    assign byte_done = rise && (cnt == 3'd7);
    assign rx_byte   = {sh, mosi_q};
    assign load_req  = fall && (cnt == 3'd0);
    assign miso_bit  = tx[7] & cs_act;

    // Count bits and shift in on rising edges; clear the frame while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            cnt <= 3'd0;
            sh  <= 7'd0;
        end else if (rise) begin
            cnt <= cnt + 3'd1;
            sh  <= {sh[5:0], mosi_q};
        end
    end

    // Load a fresh output byte at a byte boundary, otherwise shift out.
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_act) begin
            tx <= 8'd0;
        end else if (fall) begin
            tx <= load_req ? load_byte : {tx[6:0], 1'b0};
        end
    end

    // R10: every frame starts with an empty bit count.
    a_r10_fresh_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_q) |-> (cnt == 3'd0));
endmodule

// File: rtl/spi_dual_protect.sv
// Block-protect decode: flags an address that the protect setting blocks.
// Assumes ADDR_W >= 2; ranges are none, upper quarter, upper half, all.
module spi_dual_protect #(
    parameter int ADDR_W = 15
) (
    input  logic [1:0]        bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              blocked
);
    // Compare the top address bits against the selected range.
    always_comb begin
        case (bp)
            2'b00:   blocked = 1'b0;
            2'b01:   blocked = (addr[ADDR_W-1:ADDR_W-2] == 2'b11);
            2'b10:   blocked = addr[ADDR_W-1];
            default: blocked = 1'b1;
        endcase
    end
endmodule

// File: rtl/spi_dual_front.sv
// Dual-device SPI slave front end: decodes memory and companion opcode
// spaces, sequences address/data bytes with auto-increment, and gates memory
// writes by the write-enable latch, block-protect bits and lockout.
// Assumes external storage with combinational read data; 8 <= ADDR_W <= 16.
module spi_dual_front
    import spi_dual_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int NREG   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    input  logic              lockout,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    output logic [((NREG > 1) ? $clog2(NREG) : 1)-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    input  logic [7:0]        reg_rdata
);
    localparam int RAW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [RAW-1:0] LAST_REG = RAW'(NREG - 1);

    phase_t            phase;
    logic              cs_act, byte_done, load_req, blocked;
    logic [7:0]        rx_byte, load_byte, status_byte;
    logic [ADDR_W-1:0] ptr;
    logic [RAW-1:0]    cptr, cinc;
    logic [1:0]        bp;
    logic              wel, wr_cmd, is_wr, ign;

    spi_dual_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .mosi      (mosi),
        .load_byte (load_byte),
        .cs_act    (cs_act),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .load_req  (load_req),
        .miso_bit  (miso)
    );

    spi_dual_protect #(.ADDR_W(ADDR_W)) u_prot (
        .bp      (bp),
        .addr    (ptr),
        .blocked (blocked)
    );

    assign status_byte = {4'b0000, bp, wel, 1'b0};
    assign cinc        = (cptr == LAST_REG) ? '0 : cptr + 1'b1;
    assign mem_addr    = ptr;
    assign mem_wdata   = rx_byte;
    assign reg_addr    = cptr;
    assign reg_wdata   = rx_byte;
    assign mem_we      = byte_done && (phase == PH_MWR) && wel && !blocked;
    assign reg_we      = byte_done && (phase == PH_CWR);

    // Choose the byte to send next from the active read phase.
    always_comb begin
        case (phase)
            PH_MRD:  load_byte = mem_rdata;
            PH_SRD:  load_byte = status_byte;
            PH_CRD:  load_byte = reg_rdata;
            default: load_byte = 8'd0;
        endcase
    end

    // Transaction sequencer: opcode decode, address build, pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_OPC;
            ptr    <= '0;
            cptr   <= '0;
            bp     <= 2'b00;
            wel    <= 1'b0;
            wr_cmd <= 1'b0;
            is_wr  <= 1'b0;
            ign    <= 1'b0;
        end else if (!cs_act) begin
            phase  <= PH_OPC;
            ign    <= lockout;
            wr_cmd <= 1'b0;
            if (wr_cmd) wel <= 1'b0;
        end else if (byte_done) begin
            case (phase)
                PH_OPC: begin
                    phase <= PH_IGN;
                    if (!ign) begin
                        case (rx_byte)
                            OP_WREN:  wel <= 1'b1;
                            OP_WRDI:  wel <= 1'b0;
                            OP_RDSR:  phase <= PH_SRD;
                            OP_WRSR:  begin phase <= PH_SWR; wr_cmd <= 1'b1; end
                            OP_READ:  begin phase <= PH_AHI; is_wr <= 1'b0; end
                            OP_WRITE: begin phase <= PH_AHI; is_wr <= 1'b1; wr_cmd <= 1'b1; end
                            OP_CWR:   begin phase <= PH_CADR; is_wr <= 1'b1; end
                            OP_CRD:   begin phase <= PH_CADR; is_wr <= 1'b0; end
                            default:  phase <= PH_IGN;
                        endcase
                    end
                end
                PH_AHI: begin
                    ptr   <= ADDR_W'({ptr, rx_byte});
                    phase <= PH_ALO;
                end
                PH_ALO: begin
                    ptr   <= ADDR_W'({ptr, rx_byte});
                    phase <= is_wr ? PH_MWR : PH_MRD;
                end
                PH_MWR: ptr <= ptr + 1'b1;
                PH_SWR: begin
                    if (wel) bp <= rx_byte[3:2];
                    phase <= PH_IGN;
                end
                PH_CADR: begin
                    cptr  <= RAW'(rx_byte);
                    phase <= is_wr ? PH_CWR : PH_CRD;
                end
                PH_CWR: cptr <= cinc;
                default: ;
            endcase
        end else if (load_req) begin
            if (phase == PH_MRD) ptr <= ptr + 1'b1;
            if (phase == PH_CRD) cptr <= cinc;
        end
    end

    // R5: a memory write only happens inside a write-opcode transaction.
    a_r5_write_in_write_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wr_cmd);
    // R5: deselect after a write-type command leaves the latch clear.
    a_r5_latch_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && wr_cmd) |=> !wel);
    // R7: full protection admits no memory write.
    a_r7_full_protect: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (bp != 2'b11));
    // R8: the companion pointer wraps after the last register.
    a_r8_reg_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == LAST_REG)) |=> (reg_addr == '0));
    // R9: a locked-out transaction writes nothing.
    a_r9_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ign |-> !(mem_we || reg_we));
    // R11: memory and companion strobes never coincide.
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, reg_we}));
endmodule

// File: tb/sim_spi_dual_front.sv
// Bench for spi_dual_front with a 256-byte array and 30 registers.
module sim_spi_dual_front;
    localparam int AW = 8;
    localparam int NR = 30;
    localparam int H  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, lockout = 1'b0;
    logic miso, mem_we, reg_we;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_wdata, mem_rdata, reg_wdata, reg_rdata;
    logic [4:0] reg_addr;

    logic [7:0] bmem [256];
    logic [7:0] breg [NR];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_reg [NR];
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    spi_dual_front #(.ADDR_W(AW), .NREG(NR)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .lockout(lockout),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    assign mem_rdata = bmem[mem_addr];
    assign reg_rdata = (reg_addr < 5'(NR)) ? breg[reg_addr] : 8'h00;

    always @(posedge clk) begin
        if (mem_we) bmem[mem_addr] <= mem_wdata;
        if (reg_we && reg_addr < 5'(NR)) breg[reg_addr] <= reg_wdata;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] o, input int nbits, output logic [7:0] i);
        i = 8'h00;
        for (int b = 7; b > 7 - nbits; b--) begin
            mosi = o[b];
            repeat (H) @(negedge clk);
            i[b] = miso;
            sclk = 1'b1;
            repeat (H) @(negedge clk);
            sclk = 1'b0;
        end
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic desel();
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] op);
        logic [7:0] d;
        sel(); xfer(op, 8, d); desel();
    endtask

    task automatic rdsr(output logic [7:0] s);
        logic [7:0] d;
        sel(); xfer(8'h05, 8, d); xfer(8'h00, 8, s); desel();
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] d;
        sel(); xfer(8'h01, 8, d); xfer(v, 8, d); desel();
    endtask

    function automatic logic [7:0] dpat(input int seed, input int idx);
        return 8'((idx * 7 + seed * 31 + 3) ^ (idx >> 3));
    endfunction

    function automatic bit prot(input int bp, input int a);
        case (bp)
            0: return 1'b0;
            1: return a >= 192;
            2: return a >= 128;
            default: return 1'b1;
        endcase
    endfunction

    // Burst-write n bytes from start; expected array updated when allowed.
    task automatic mem_write(input int start, input int n, input int seed, input int bp, input bit wel);
        logic [7:0] d;
        sel();
        xfer(8'h02, 8, d); xfer(8'(start >> 8), 8, d); xfer(8'(start), 8, d);
        for (int k = 0; k < n; k++) begin
            int a = (start + k) % 256;
            xfer(dpat(seed, k), 8, d);
            if (wel && !prot(bp, a)) exp_mem[a] = dpat(seed, k);
        end
        desel();
    endtask

    task automatic mem_read(input int start, input int n, input string tag);
        logic [7:0] d;
        sel();
        xfer(8'h03, 8, d); xfer(8'(start >> 8), 8, d); xfer(8'(start), 8, d);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, d);
            chk(tag, d, exp_mem[(start + k) % 256]);
        end
        desel();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s, d;
        for (int a = 0; a < 256; a++) begin bmem[a] = 8'h00; exp_mem[a] = 8'h00; end
        for (int r = 0; r < NR; r++) begin breg[r] = 8'h00; exp_reg[r] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: idle output and status after reset.
        chk("R1 miso idle", miso, 0);
        rdsr(s); chk("R1 status reset", s, 8'h00);

        // R5: write without latch is discarded.
        mem_write(5, 1, 9, 0, 1'b0);
        mem_read(5, 1, "R5 no latch write");

        // R4: latch set and clear through status.
        cmd(8'h06); rdsr(s); chk("R4 latch set", s, 8'h02);
        cmd(8'h04); rdsr(s); chk("R4 latch clear", s, 8'h00);

        // R3 / R2: full-array burst, then read back with wrap.
        cmd(8'h06);
        mem_write(0, 256, 1, 0, 1'b1);
        rdsr(s); chk("R5 latch cleared after write", s, 8'h00);
        mem_read(0, 258, "R2 burst read");
        cmd(8'h06);
        mem_write(16'hFFFF, 3, 2, 0, 1'b1);
        mem_read(254, 4, "R3 write wrap");

        // R6 / R7: every protect setting against every address.
        for (int bp = 0; bp < 4; bp++) begin
            cmd(8'h06); wrsr(8'(bp << 2));
            rdsr(s); chk("R6 protect load", s, bp << 2);
            cmd(8'h06);
            mem_write(0, 256, 10 + bp, bp, 1'b1);
            mem_read(0, 256, "R7 protect range");
        end
        wrsr(8'h00); rdsr(s); chk("R6 no latch no change", s, 8'h0C);

        // R8: companion registers ignore latch and protect, wrap at NR.
        sel();
        xfer(8'h12, 8, d); xfer(8'd28, 8, d);
        for (int k = 0; k < NR; k++) begin
            xfer(8'(8'h40 + k), 8, d);
            exp_reg[(28 + k) % NR] = 8'(8'h40 + k);
        end
        desel();
        sel();
        xfer(8'h13, 8, d); xfer(8'd0, 8, d);
        for (int k = 0; k < NR + 2; k++) begin
            xfer(8'h00, 8, d);
            chk("R8 companion read", d, exp_reg[k % NR]);
        end
        desel();
        cmd(8'h06); wrsr(8'h00); rdsr(s); chk("R6 protect cleared", s, 8'h00);

        // R9: lockout blocks latch set, reads and writes.
        lockout = 1'b1; cmd(8'h06); lockout = 1'b0;
        rdsr(s); chk("R9 latch untouched", s, 8'h00);
        cmd(8'h06);
        lockout = 1'b1;
        sel();
        xfer(8'h03, 8, d); xfer(8'h00, 8, d); xfer(8'd9, 8, d); xfer(8'h00, 8, d);
        desel();
        chk("R9 miso silent", d, 8'h00);
        mem_write(9, 1, 50, 0, 1'b0);
        lockout = 1'b0;
        mem_read(9, 1, "R9 write dropped");
        rdsr(s); chk("R9 latch kept", s, 8'h02);

        // R10: a cut-off data byte is not committed.
        sel();
        xfer(8'h02, 8, d); xfer(8'h00, 8, d); xfer(8'd20, 8, d); xfer(8'hFF, 5, d);
        desel();
        mem_read(20, 1, "R10 partial byte");

        // R11: unknown opcode changes nothing.
        cmd(8'h06);
        sel(); xfer(8'h5A, 8, d); xfer(8'h00, 8, d); xfer(8'd30, 8, d); xfer(8'hEE, 8, d); desel();
        rdsr(s); chk("R11 status kept", s, 8'h02);
        mem_read(30, 1, "R11 memory kept");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule